// File: doc/BRIEF.md
# Composite Structure Walker

The walker keeps a hidden pointer behind a single data register. It moves that register through a data structure held in byte-addressed memory. A host first sends an init command. The init command carries a descriptor:

- the structure kind: zero-terminated string, count-prefixed string, padded array, or linked list;
- a base address;
- an element size;
- an array stride and length;
- for lists, the byte offsets of the data field and the link fields.

The walker fetches the first element into the data register. Step commands then move one element forward or backward. A step can first store a new value into the current element. An address command copies the current element's memory address into the data register. The host can then take over for insertions and deletions.

The memory side issues one byte request at a time over a valid/ready request channel. Each request, read or write, is answered by exactly one response pulse. Multi-byte elements and link pointers are assembled little-endian, with the lowest address in the least significant byte.

Top module: `comp_walker`

## Requirements
- R1: Reset state. After reset, `busy_o`, `end_o`, `begin_o` and `mem_req_valid` are 0 and `data_o` is 0.
- R2: Zero-terminated string, init (kind 0). Init loads the byte at the base address. If that byte is zero, `end_o` is set and `data_o` is 0.
- R3: Zero-terminated string, forward step. The step reads the byte at the current address plus one. If that byte is zero, `end_o` is set and both `data_o` and the current address keep their values.
- R4: Count-prefixed string (kind 1). The byte at the base address is the length. The first data byte is at base plus one. A forward step from the last counted byte sets `end_o` and issues no memory request. A length of zero sets `end_o` with `data_o` at 0.
- R5: Padded array (kind 2). Element i starts at base + i·stride and is `cfg_esize` bytes long, read little-endian. A forward step from element length−1 sets `end_o` and issues no memory request.
- R6: Backward step at the first element. For strings, arrays and lists, such a step sets `begin_o`, leaves `data_o` and the position unchanged and issues no memory request. `end_o` and `begin_o` are never high together.
- R7: Linked-list load (kind 3). Loading a node reads its data field at node+`cfg_doff`, then a 2-byte next pointer at node+`cfg_noff`. If `cfg_dbl`=1 it also reads a 2-byte previous pointer at node+`cfg_poff`. An init with base 0 sets `end_o`.
- R8: Linked-list steps. A forward step goes to the next pointer. A backward step on a doubly linked list goes to the previous pointer. A zero pointer, or a backward step on a singly linked list, sets `end_o` (forward) or `begin_o` (backward) with no memory request.
- R9: Write step (mode 1). The step writes `cmd_wdata` into the current element's bytes, little-endian. `data_o` becomes `cmd_wdata` and the position does not change.
- R10: Read/write step (mode 2 or 3). The step first writes `cmd_wdata` to the current element, then moves and loads as in a read step (mode 0).
- R11: Address command (op 3). It copies the current element address into `data_o` on the next cycle, zero-extended. It makes no memory request and never raises `busy_o`. For a list, the address is the node address.
- R12: Busy. `busy_o` rises the cycle after a command is accepted (op 1 init, op 2 step) and stays high until the element, including any list pointers, is loaded. A command presented while `busy_o` is high is ignored. `end_o` and `begin_o` are cleared by each accepted init or step.
- R13: Memory port. At most one request is outstanding. A request not yet accepted keeps its valid, address and write enable stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when `busy_o` is low |
| cmd_op | input | 2 | 1 init, 2 step, 3 address, 0 none |
| cmd_dir | input | 1 | Step direction: 0 forward, 1 backward |
| cmd_mode | input | 2 | Step mode: 0 read, 1 write, 2/3 write then read |
| cmd_wdata | input | DW | Value stored by write steps |
| cfg_kind | input | 2 | 0 zero-terminated string, 1 counted string, 2 array, 3 list |
| cfg_base | input | AW | First element or node address |
| cfg_esize | input | 3 | Element bytes for array and list data (1..DW/8) |
| cfg_stride | input | STRW | Array element pitch in bytes |
| cfg_count | input | AW | Array length |
| cfg_doff | input | OFFW | List data field offset |
| cfg_noff | input | OFFW | List next-pointer offset |
| cfg_poff | input | OFFW | List previous-pointer offset |
| cfg_dbl | input | 1 | List is doubly linked |
| busy_o | output | 1 | Command in progress |
| data_o | output | DW | The composite data register |
| end_o | output | 1 | Last command ran off the end |
| begin_o | output | 1 | Last command ran off the start |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address |
| mem_req_we | output | 1 | Write request |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 8 | Read byte |

## Verification
The last memory response of a step can arrive in the same cycle as a new host command. The step loads its data on the edge where `busy_o` falls, so at that edge the new command would race the register update. The bench presents an address command on every cycle while a string step is in flight, including the cycle of the final response. It then checks that `data_o` holds the stepped byte rather than an address, and that no extra memory traffic occurred.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [1:0] {
        K_ZSTR = 2'd0,
        K_CSTR = 2'd1,
        K_ARR  = 2'd2,
        K_LIST = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INIT = 2'd1,
        OP_STEP = 2'd2,
        OP_ADDR = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CNT,
        S_WR,
        S_DATA,
        S_NPTR,
        S_PPTR
    } state_e;

endpackage

// File: rtl/walk_nav.sv
module walk_nav
    import walk_pkg::*;
#(
    parameter int AW   = 16,
    parameter int STRW = 8
) (
    input  kind_e           kind,
    input  logic            back,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   cur,
    input  logic [AW-1:0]   idx,
    input  logic [AW-1:0]   cnt,
    input  logic [STRW-1:0] stride,
    input  logic [AW-1:0]   nptr,
    input  logic [AW-1:0]   pptr,
    input  logic            dbl,
    output logic            hit_end,
    output logic            hit_begin,
    output logic [AW-1:0]   tgt,
    output logic [AW-1:0]   idx_nx
);

    logic [AW:0]   idx_inc;
    logic [AW-1:0] pitch;

    always_comb begin
        idx_inc   = {1'b0, idx} + {{AW{1'b0}}, 1'b1};
        pitch     = (kind == K_ARR) ? AW'(stride) : AW'(1);
        hit_end   = 1'b0;
        hit_begin = 1'b0;
        tgt       = cur;
        idx_nx    = idx;
        unique case (kind)
            K_ZSTR: begin
                if (back) begin
                    hit_begin = (cur == base);
                    tgt       = cur - pitch;
                end else begin
                    tgt       = cur + pitch;
                end
            end
            K_CSTR, K_ARR: begin
                if (back) begin
                    hit_begin = (idx == '0);
                    tgt       = cur - pitch;
                    idx_nx    = idx - AW'(1);
                end else begin
                    hit_end   = (idx_inc >= {1'b0, cnt});
                    tgt       = cur + pitch;
                    idx_nx    = idx_inc[AW-1:0];
                end
            end
            default: begin
                if (back) begin
                    hit_begin = !dbl || (pptr == '0);
                    tgt       = pptr;
                end else begin
                    hit_end   = (nptr == '0);
                    tgt       = nptr;
                end
            end
        endcase
    end

endmodule

// File: rtl/walk_bus.sv
module walk_bus #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int ESW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  addr,
    input  logic [ESW-1:0] nbytes,
    input  logic           we,
    input  logic [DW-1:0]  wdata,
    output logic           done,
    output logic [DW-1:0]  rdata,
    output logic           req_valid,
    input  logic           req_ready,
    output logic [AW-1:0]  req_addr,
    output logic           req_we,
    output logic [7:0]     req_wdata,
    input  logic           rsp_valid,
    input  logic [7:0]     rsp_rdata
);

    typedef struct packed {
        logic           active;
        logic           pend;
        logic [ESW-1:0] bcnt;
        logic [DW-1:0]  asm;
        logic           done;
    } bus_t;

    bus_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.active = 1'b1;
            d.pend   = 1'b0;
            d.bcnt   = '0;
            d.asm    = '0;
        end else if (q.active) begin
            if (!q.pend && req_ready) begin
                d.pend = 1'b1;
            end
            if (q.pend && rsp_valid) begin
                d.pend = 1'b0;
                if (!we) begin
                    d.asm[{q.bcnt, 3'b000} +: 8] = rsp_rdata;
                end
                if (q.bcnt == nbytes - ESW'(1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.bcnt = q.bcnt + ESW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_valid = q.active && !q.pend;
    assign req_addr  = addr + AW'(q.bcnt);
    assign req_we    = we;
    assign req_wdata = wdata[{q.bcnt, 3'b000} +: 8];
    assign done      = q.done;
    assign rdata     = q.asm;

endmodule

// File: rtl/comp_walker.sv
module comp_walker
    import walk_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int OFFW = 8,
    parameter int STRW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic            cmd_dir,
    input  logic [1:0]      cmd_mode,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic [1:0]      cfg_kind,
    input  logic [AW-1:0]   cfg_base,
    input  logic [2:0]      cfg_esize,
    input  logic [STRW-1:0] cfg_stride,
    input  logic [AW-1:0]   cfg_count,
    input  logic [OFFW-1:0] cfg_doff,
    input  logic [OFFW-1:0] cfg_noff,
    input  logic [OFFW-1:0] cfg_poff,
    input  logic            cfg_dbl,
    output logic            busy_o,
    output logic [DW-1:0]   data_o,
    output logic            end_o,
    output logic            begin_o,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    output logic            mem_req_we,
    output logic [7:0]      mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [7:0]      mem_rsp_rdata
);

    localparam int EB  = DW / 8;
    localparam int ESW = $clog2(EB) + 1;
    localparam int PB  = AW / 8;

    typedef struct packed {
        state_e          st;
        kind_e           kind;
        logic [AW-1:0]   base;
        logic [AW-1:0]   cur;
        logic [AW-1:0]   tgt;
        logic [AW-1:0]   cnt;
        logic [AW-1:0]   idx;
        logic [AW-1:0]   idx_t;
        logic [AW-1:0]   nptr;
        logic [AW-1:0]   pptr;
        logic [AW-1:0]   baddr;
        logic [ESW-1:0]  esz;
        logic [ESW-1:0]  bn;
        logic [STRW-1:0] stride;
        logic [OFFW-1:0] doff;
        logic [OFFW-1:0] noff;
        logic [OFFW-1:0] poff;
        logic [DW-1:0]   data;
        logic [DW-1:0]   bwd;
        logic            dbl;
        logic            busy;
        logic            endf;
        logic            begf;
        logic            init;
        logic            move;
        logic            back;
        logic            bwe;
        logic            go;
    } walk_t;

    walk_t q, d;

    logic          nav_back, nav_end, nav_begin;
    logic [AW-1:0] nav_tgt, nav_idx;
    logic          bus_done;
    logic [DW-1:0] bus_rdata;
    kind_e         cfg_kind_e;
    logic [ESW-1:0] esz_cfg;

    assign cfg_kind_e = kind_e'(cfg_kind);
    assign nav_back   = (q.st == S_IDLE) ? cmd_dir : q.back;

    function automatic walk_t launch(walk_t s, state_e st, logic [AW-1:0] a,
                                     logic [ESW-1:0] nb, logic we);
        s.st    = st;
        s.baddr = a;
        s.bn    = nb;
        s.bwe   = we;
        s.go    = 1'b1;
        s.busy  = 1'b1;
        return s;
    endfunction

    function automatic walk_t finish(walk_t s);
        s.st   = S_IDLE;
        s.busy = 1'b0;
        return s;
    endfunction

    function automatic logic [AW-1:0] field_addr(walk_t s, logic [AW-1:0] a);
        return (s.kind == K_LIST) ? a + AW'(s.doff) : a;
    endfunction

    function automatic walk_t do_move(walk_t s, logic e, logic b,
                                      logic [AW-1:0] t, logic [AW-1:0] ix);
        if (e) begin
            s.endf = 1'b1;
            s = finish(s);
        end else if (b) begin
            s.begf = 1'b1;
            s = finish(s);
        end else begin
            s.tgt   = t;
            s.idx_t = ix;
            s = launch(s, S_DATA, field_addr(s, t), s.esz, 1'b0);
        end
        return s;
    endfunction

    always_comb begin
        if (cfg_kind_e == K_ZSTR || cfg_kind_e == K_CSTR || cfg_esize == 3'd0) begin
            esz_cfg = ESW'(1);
        end else if (int'(cfg_esize) > EB) begin
            esz_cfg = ESW'(EB);
        end else begin
            esz_cfg = ESW'(cfg_esize);
        end
    end

    walk_nav #(.AW(AW), .STRW(STRW)) u_nav (
        .kind      (q.kind),
        .back      (nav_back),
        .base      (q.base),
        .cur       (q.cur),
        .idx       (q.idx),
        .cnt       (q.cnt),
        .stride    (q.stride),
        .nptr      (q.nptr),
        .pptr      (q.pptr),
        .dbl       (q.dbl),
        .hit_end   (nav_end),
        .hit_begin (nav_begin),
        .tgt       (nav_tgt),
        .idx_nx    (nav_idx)
    );

    walk_bus #(.AW(AW), .DW(DW), .ESW(ESW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (q.go),
        .addr      (q.baddr),
        .nbytes    (q.bn),
        .we        (q.bwe),
        .wdata     (q.bwd),
        .done      (bus_done),
        .rdata     (bus_rdata),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .req_addr  (mem_req_addr),
        .req_we    (mem_req_we),
        .req_wdata (mem_req_wdata),
        .rsp_valid (mem_rsp_valid),
        .rsp_rdata (mem_rsp_rdata)
    );

    always_comb begin
        d    = q;
        d.go = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_e'(cmd_op))
                        OP_INIT: begin
                            d.kind   = cfg_kind_e;
                            d.base   = cfg_base;
                            d.cur    = cfg_base;
                            d.tgt    = cfg_base;
                            d.cnt    = cfg_count;
                            d.stride = cfg_stride;
                            d.doff   = cfg_doff;
                            d.noff   = cfg_noff;
                            d.poff   = cfg_poff;
                            d.dbl    = cfg_dbl;
                            d.esz    = esz_cfg;
                            d.nptr   = '0;
                            d.pptr   = '0;
                            d.idx    = '0;
                            d.idx_t  = '0;
                            d.endf   = 1'b0;
                            d.begf   = 1'b0;
                            d.init   = 1'b1;
                            d.back   = 1'b0;
                            unique case (cfg_kind_e)
                                K_ZSTR: d = launch(d, S_DATA, cfg_base, ESW'(1), 1'b0);
                                K_CSTR: d = launch(d, S_CNT, cfg_base, ESW'(1), 1'b0);
                                K_ARR: begin
                                    if (cfg_count == '0) begin
                                        d.endf = 1'b1;
                                        d.data = '0;
                                    end else begin
                                        d = launch(d, S_DATA, cfg_base, esz_cfg, 1'b0);
                                    end
                                end
                                default: begin
                                    if (cfg_base == '0) begin
                                        d.endf = 1'b1;
                                        d.data = '0;
                                    end else begin
                                        d = launch(d, S_DATA, cfg_base + AW'(cfg_doff),
                                                   esz_cfg, 1'b0);
                                    end
                                end
                            endcase
                        end
                        OP_STEP: begin
                            d.endf = 1'b0;
                            d.begf = 1'b0;
                            d.init = 1'b0;
                            d.back = cmd_dir;
                            if (cmd_mode != 2'd0) begin
                                d.data = cmd_wdata;
                                d.bwd  = cmd_wdata;
                                d.move = (cmd_mode != 2'd1);
                                d = launch(d, S_WR, field_addr(q, q.cur), q.esz, 1'b1);
                            end else begin
                                d = do_move(d, nav_end, nav_begin, nav_tgt, nav_idx);
                            end
                        end
                        OP_ADDR: d.data = DW'(q.cur);
                        default: ;
                    endcase
                end
            end
            S_CNT: begin
                if (bus_done) begin
                    d.cnt = AW'(bus_rdata[7:0]);
                    if (bus_rdata[7:0] == 8'h00) begin
                        d.endf = 1'b1;
                        d.data = '0;
                        d = finish(d);
                    end else begin
                        d.tgt   = q.base + AW'(1);
                        d.idx_t = '0;
                        d = launch(d, S_DATA, q.base + AW'(1), ESW'(1), 1'b0);
                    end
                end
            end
            S_WR: begin
                if (bus_done) begin
                    if (q.move) begin
                        d = do_move(d, nav_end, nav_begin, nav_tgt, nav_idx);
                    end else begin
                        d = finish(d);
                    end
                end
            end
            S_DATA: begin
                if (bus_done) begin
                    if (q.kind == K_ZSTR && !q.back && bus_rdata[7:0] == 8'h00) begin
                        d.endf = 1'b1;
                        if (q.init) begin
                            d.data = '0;
                            d.cur  = q.tgt;
                        end
                        d = finish(d);
                    end else begin
                        d.data = bus_rdata;
                        d.cur  = q.tgt;
                        d.idx  = q.idx_t;
                        if (q.kind == K_LIST) begin
                            d = launch(d, S_NPTR, q.tgt + AW'(q.noff), ESW'(PB), 1'b0);
                        end else begin
                            d = finish(d);
                        end
                    end
                end
            end
            S_NPTR: begin
                if (bus_done) begin
                    d.nptr = bus_rdata[AW-1:0];
                    if (q.dbl) begin
                        d = launch(d, S_PPTR, q.cur + AW'(q.poff), ESW'(PB), 1'b0);
                    end else begin
                        d = finish(d);
                    end
                end
            end
            S_PPTR: begin
                if (bus_done) begin
                    d.pptr = bus_rdata[AW-1:0];
                    d = finish(d);
                end
            end
            default: d = finish(d);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.kind <= K_ZSTR;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = q.busy;
    assign data_o  = q.data;
    assign end_o   = q.endf;
    assign begin_o = q.begf;

endmodule

// File: rtl/comp_walker_chk.sv
module comp_walker_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy_o,
    input logic [DW-1:0] data_o,
    input logic          end_o,
    input logic          begin_o,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_req_we,
    input logic          mem_rsp_valid
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            pend_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_we));

    assert_single_outstanding_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid);

    assert_rsp_matches_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> pend_q);

    assert_no_req_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_valid);

    assert_busy_from_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_valid));

    assert_data_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !cmd_valid |=> $stable(data_o));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_o && begin_o));

endmodule

bind comp_walker comp_walker_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .busy_o        (busy_o),
    .data_o        (data_o),
    .end_o         (end_o),
    .begin_o       (begin_o),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_we    (mem_req_we),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/comp_walker_test.sv
`timescale 1ns/1ps
module comp_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_dir = 1'b0;
    logic [1:0]  cmd_mode = 2'd0;
    logic [31:0] cmd_wdata = '0;
    logic [1:0]  cfg_kind = 2'd0;
    logic [15:0] cfg_base = '0;
    logic [2:0]  cfg_esize = 3'd1;
    logic [7:0]  cfg_stride = 8'd1;
    logic [15:0] cfg_count = '0;
    logic [7:0]  cfg_doff = '0;
    logic [7:0]  cfg_noff = '0;
    logic [7:0]  cfg_poff = '0;
    logic        cfg_dbl = 1'b0;
    logic        busy_o, end_o, begin_o;
    logic [31:0] data_o;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b1;
    logic [15:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_rdata = '0;

    logic [7:0]  mem [0:1023];
    int          reqcnt = 0;
    int          checks = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    comp_walker uut (.*);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem[mem_req_addr[9:0]];
            if (mem_req_we) mem[mem_req_addr[9:0]] <= mem_req_wdata;
            reqcnt <= reqcnt + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  op;
        logic        dir;
        logic [1:0]  mode;
        logic [31:0] wd;
        logic [31:0] xd;
        logic        xe;
        logic        xb;
        logic [7:0]  xr;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd1, 1'b0, 2'd0, 32'h0, 32'h41,       1'b0, 1'b0, 8'd1}, // R2 init
        '{2'd0, 2'd2, 1'b1, 2'd0, 32'h0, 32'h41,       1'b0, 1'b1, 8'd0}, // R6 back at first
        '{2'd0, 2'd2, 1'b0, 2'd0, 32'h0, 32'h42,       1'b0, 1'b0, 8'd1}, // R3 forward
        '{2'd0, 2'd2, 1'b0, 2'd0, 32'h0, 32'h42,       1'b1, 1'b0, 8'd1}, // R3 terminator
        '{2'd0, 2'd3, 1'b0, 2'd0, 32'h0, 32'h11,       1'b1, 1'b0, 8'd0}, // R11 address
        '{2'd1, 2'd1, 1'b0, 2'd0, 32'h0, 32'h78,       1'b0, 1'b0, 8'd2}, // R4 init
        '{2'd1, 2'd2, 1'b0, 2'd0, 32'h0, 32'h79,       1'b0, 1'b0, 8'd1}, // R4
        '{2'd1, 2'd2, 1'b0, 2'd0, 32'h0, 32'h7A,       1'b0, 1'b0, 8'd1}, // R4
        '{2'd1, 2'd2, 1'b0, 2'd0, 32'h0, 32'h7A,       1'b1, 1'b0, 8'd0}, // R4 past count
        '{2'd1, 2'd2, 1'b1, 2'd0, 32'h0, 32'h79,       1'b0, 1'b0, 8'd1}, // R4 back
        '{2'd1, 2'd3, 1'b0, 2'd0, 32'h0, 32'h22,       1'b0, 1'b0, 8'd0}, // R11
        '{2'd2, 2'd1, 1'b0, 2'd0, 32'h0, 32'hA1B2,     1'b0, 1'b0, 8'd2}, // R5 init
        '{2'd2, 2'd2, 1'b0, 2'd0, 32'h0, 32'hC3D4,     1'b0, 1'b0, 8'd2}, // R5 stride
        '{2'd2, 2'd2, 1'b0, 2'd2, 32'h0BEE, 32'hE5F6,  1'b0, 1'b0, 8'd4}, // R10
        '{2'd2, 2'd2, 1'b1, 2'd0, 32'h0, 32'h0BEE,     1'b0, 1'b0, 8'd2}, // R10 stored
        '{2'd2, 2'd2, 1'b0, 2'd1, 32'h1234, 32'h1234,  1'b0, 1'b0, 8'd2}, // R9 write
        '{2'd2, 2'd3, 1'b0, 2'd0, 32'h0, 32'h44,       1'b0, 1'b0, 8'd0}, // R9 no move
        '{2'd2, 2'd2, 1'b0, 2'd0, 32'h0, 32'hE5F6,     1'b0, 1'b0, 8'd2}, // R5
        '{2'd2, 2'd2, 1'b0, 2'd0, 32'h0, 32'hE5F6,     1'b1, 1'b0, 8'd0}, // R5 past last
        '{2'd3, 2'd1, 1'b0, 2'd0, 32'h0, 32'h11223344, 1'b0, 1'b0, 8'd8}, // R7 init
        '{2'd3, 2'd2, 1'b1, 2'd0, 32'h0, 32'h11223344, 1'b0, 1'b1, 8'd0}, // R8 prev zero
        '{2'd3, 2'd2, 1'b0, 2'd0, 32'h0, 32'h55667788, 1'b0, 1'b0, 8'd8}, // R8 next
        '{2'd3, 2'd2, 1'b0, 2'd0, 32'h0, 32'h55667788, 1'b1, 1'b0, 8'd0}, // R8 next zero
        '{2'd3, 2'd3, 1'b0, 2'd0, 32'h0, 32'h140,      1'b1, 1'b0, 8'd0}, // R11 node addr
        '{2'd3, 2'd2, 1'b1, 2'd0, 32'h0, 32'h11223344, 1'b0, 1'b0, 8'd8}  // R8 prev
    };

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] k);
        cfg_kind   = k;
        cfg_dbl    = 1'b1;
        cfg_esize  = 3'd1;
        cfg_stride = 8'd1;
        cfg_count  = '0;
        case (k)
            2'd0: cfg_base = 16'h0010;
            2'd1: cfg_base = 16'h0020;
            2'd2: begin
                cfg_base = 16'h0040; cfg_esize = 3'd2; cfg_stride = 8'd4; cfg_count = 16'd3;
            end
            default: begin
                cfg_base = 16'h0100; cfg_esize = 3'd4;
                cfg_doff = 8'd0; cfg_noff = 8'd4; cfg_poff = 8'd6;
            end
        endcase
    endtask

    task automatic issue(input logic [1:0] op, input logic dir, input logic [1:0] mode,
                         input logic [31:0] wd);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_dir   = dir;
        cmd_mode  = mode;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[16'h10] = 8'h41; mem[16'h11] = 8'h42;
        mem[16'h20] = 8'd3;  mem[16'h21] = 8'h78; mem[16'h22] = 8'h79; mem[16'h23] = 8'h7A;
        mem[16'h40] = 8'hB2; mem[16'h41] = 8'hA1;
        mem[16'h44] = 8'hD4; mem[16'h45] = 8'hC3;
        mem[16'h48] = 8'hF6; mem[16'h49] = 8'hE5;
        mem[16'h100] = 8'h44; mem[16'h101] = 8'h33; mem[16'h102] = 8'h22; mem[16'h103] = 8'h11;
        mem[16'h104] = 8'h40; mem[16'h105] = 8'h01;
        mem[16'h140] = 8'h88; mem[16'h141] = 8'h77; mem[16'h142] = 8'h66; mem[16'h143] = 8'h55;
        mem[16'h146] = 8'h00; mem[16'h147] = 8'h01;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {28'd0, busy_o, end_o, begin_o, mem_req_valid, data_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v].kind);
            r0 = reqcnt;
            issue(VEC[v].op, VEC[v].dir, VEC[v].mode, VEC[v].wd);
            check($sformatf("vector %0d (R2..R11)", v),
                  {VEC[v].xr, 22'd0, end_o, begin_o, data_o},
                  {8'(reqcnt - r0), 22'd0, VEC[v].xe, VEC[v].xb, VEC[v].xd});
        end

        // R10 memory image after read/write step and write step
        check("R10 mem", {56'd0, mem[16'h45]}, 64'h12);
        check("R9 mem",  {56'd0, mem[16'h44]}, 64'h34);

        // R12 busy timing and collision with final response
        set_cfg(2'd0);
        issue(2'd1, 1'b0, 2'd0, 32'h0);
        r0 = reqcnt;
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_dir = 1'b0; cmd_mode = 2'd0;
        @(negedge clk);
        check("R12 busy after accept", {63'd0, busy_o}, 64'd1);
        cmd_op = 2'd3;
        while (busy_o) @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        @(negedge clk);
        check("R12 ignored while busy", {8'(reqcnt - r0), 24'd0, data_o}, {8'd1, 24'd0, 32'h42});

        // R13 stalled request
        set_cfg(2'd2);
        mem_req_ready = 1'b0;
        r0 = reqcnt;
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        repeat (5) @(negedge clk);
        check("R13 stall", {8'(reqcnt - r0), 22'd0, busy_o, mem_req_valid, data_o},
              {8'd0, 22'd0, 1'b1, 1'b1, 32'h42});
        mem_req_ready = 1'b1;
        while (busy_o) @(negedge clk);
        check("R13 after stall", {32'd0, data_o}, 64'hA1B2);

        // R8 singly linked backward
        set_cfg(2'd3);
        cfg_dbl = 1'b0;
        r0 = reqcnt;
        issue(2'd1, 1'b0, 2'd0, 32'h0);
        check("R7 singly init", {8'(reqcnt - r0), 24'd0, data_o}, {8'd6, 24'd0, 32'h11223344});
        r0 = reqcnt;
        issue(2'd2, 1'b1, 2'd0, 32'h0);
        check("R8 singly back", {8'(reqcnt - r0), 22'd0, end_o, begin_o, data_o},
              {8'd0, 22'd0, 1'b0, 1'b1, 32'h11223344});

        // R7 null list
        cfg_base = 16'h0;
        r0 = reqcnt;
        issue(2'd1, 1'b0, 2'd0, 32'h0);
        check("R7 null list", {8'(reqcnt - r0), 22'd0, end_o, begin_o, data_o},
              {8'd0, 22'd0, 1'b1, 1'b0, 32'h0});

        // R2 empty zero-terminated string
        set_cfg(2'd0);
        cfg_base = 16'h0012;
        r0 = reqcnt;
        issue(2'd1, 1'b0, 2'd0, 32'h0);
        check("R2 empty", {8'(reqcnt - r0), 22'd0, end_o, begin_o, data_o},
              {8'd1, 22'd0, 1'b1, 1'b0, 32'h0});

        // R4 zero-length counted string
        set_cfg(2'd1);
        cfg_base = 16'h0030;
        r0 = reqcnt;
        issue(2'd1, 1'b0, 2'd0, 32'h0);
        check("R4 zero count", {8'(reqcnt - r0), 22'd0, end_o, begin_o, data_o},
              {8'd1, 22'd0, 1'b1, 1'b0, 32'h0});

        // R6 array backward at first element
        set_cfg(2'd2);
        issue(2'd1, 1'b0, 2'd0, 32'h0);
        r0 = reqcnt;
        issue(2'd2, 1'b1, 2'd0, 32'h0);
        check("R6 array back", {8'(reqcnt - r0), 22'd0, end_o, begin_o, data_o},
              {8'd0, 22'd0, 1'b0, 1'b1, 32'hA1B2});

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule